// File: doc/BRIEF.md
# Password Write-Protection Controller

This block guards a small configuration register file that sits behind a byte-wide register bus. It keeps a 32-bit stored key and a 32-bit volatile entry register. Software unlocks the configuration by writing the entry register until it equals the stored key. Unlocking happens on the same cycle the two values become equal, because the comparison is made from the current register contents. While locked, the only bytes software can change are the four entry bytes. The stored key reads back as zero while locked.

The live bias and modulation DAC codes come in from the control loop. They are visible on the bus only when the loop is halted and the key matches. At all other times their bytes read as zero. A power-fail pulse returns the entry register to all ones and leaves the stored key and the configuration intact, so access is relocked. The configuration bytes drive the rest of the chip through `cfg_o`.

Address map. All multi-byte fields are most-significant byte first.

| Address | Contents |
|---|---|
| 0x00–0x03 | Entry register |
| 0x04–0x07 | Stored key |
| 0x08–0x0F | Configuration bytes (byte k at 0x08+k) |
| 0x10–0x12 | Bias code, zero-padded to 24 bits |
| 0x14–0x15 | Modulation code, zero-padded to 16 bits |

Any other address is unmapped.

Top module: `pwlock_ctrl`

## Requirements
- R1: After synchronous reset, every entry byte reads 0xFF, the stored key is 0x00000000, every configuration byte is 0x00, and access is locked.
- R2: A write to an entry byte (0x00 = bits 31:24 … 0x03 = bits 7:0) is always accepted. Access is unlocked on any cycle in which the entry register equals the stored key.
- R3: While locked, writes to the stored key bytes and the configuration bytes leave them unchanged.
- R4: While unlocked, writes to the stored key bytes (0x04 = bits 31:24 … 0x07 = bits 7:0) and the configuration bytes (0x08+k) take effect.
- R5: A stored key byte reads as 0x00 while locked and reads its true value while unlocked.
- R6: The entry bytes read their true value at all times.
- R7: A power-fail pulse sets the entry register to 0xFFFFFFFF on the next edge and leaves the stored key and the configuration unchanged. If an entry write arrives in the same cycle, the power-fail pulse wins.
- R8: The DAC code bytes (0x10–0x12 bias, 0x14–0x15 modulation, most-significant byte first) return the live input code only when halt is high and access is unlocked. Otherwise they read 0x00.
- R9: Bits above the code width in the DAC code bytes read as zero. This covers bias bits 23:18 and modulation bits 15:12.
- R10: A write that changes the stored key while unlocked takes effect on the next edge. Access is then relocked when the entry still holds the old value, and subsequent key and configuration writes are ignored.
- R11: Read data is registered. It appears on the cycle after the read strobe and holds until the next strobe. Unmapped addresses read 0x00, and writes to DAC code addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfail_i | input | 1 | Supply below analog power-good level; resets the entry register |
| halt_i | input | 1 | Control loop halted; needed to read DAC codes |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| bias_code_i | input | 18 | Live bias DAC code |
| mod_code_i | input | 12 | Live modulation DAC code |
| cfg_o | output | 64 | Configuration bytes, byte k at bits 8k+7:8k |

## Verification
The bench sweeps the whole 32-byte address window in every lock state and compares each byte against an arithmetic model. A design that exposes the stored key while locked would leak nonzero key bytes. One that masks the entry bytes would break the unlock handshake.

Changing one byte of the stored key while unlocked must relock at once. A design that latched the unlock state would let the following key and configuration writes through. A power-fail pulse coincident with an entry write must still leave all ones.

DAC reads are checked with every combination of halt and lock and with all-ones codes. This exposes designs that leak the live code, that drop one of the two conditions, or that let padding bits through.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;

    localparam int ADDR_W    = 8;
    localparam int BYTE_W    = 8;
    localparam int KEY_W     = 32;
    localparam int KEY_BYTES = KEY_W / BYTE_W;
    localparam int IDX_W     = 3;
    localparam int MAX_CFG   = 1 << IDX_W;
    localparam int WORD_W    = 32;

    localparam int BASE_ENTRY = 0;
    localparam int BASE_KEY   = BASE_ENTRY + KEY_BYTES;
    localparam int BASE_CFG   = 8;
    localparam int BASE_BIAS  = 16;
    localparam int BASE_MOD   = 20;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_ENTRY,
        REG_KEY,
        REG_CFG,
        REG_BIAS,
        REG_MOD
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   idx;
    } slot_t;

    function automatic slot_t decode_slot(input logic [ADDR_W-1:0] a,
                                          input int cfg_n,
                                          input int bias_n,
                                          input int mod_n);
        int    ai;
        slot_t s;
        ai       = int'(a);
        s.region = REG_NONE;
        s.idx    = '0;
        if (ai >= BASE_ENTRY && ai < BASE_ENTRY + KEY_BYTES) begin
            s.region = REG_ENTRY;
            s.idx    = IDX_W'(ai - BASE_ENTRY);
        end else if (ai >= BASE_KEY && ai < BASE_KEY + KEY_BYTES) begin
            s.region = REG_KEY;
            s.idx    = IDX_W'(ai - BASE_KEY);
        end else if (ai >= BASE_CFG && ai < BASE_CFG + cfg_n) begin
            s.region = REG_CFG;
            s.idx    = IDX_W'(ai - BASE_CFG);
        end else if (ai >= BASE_BIAS && ai < BASE_BIAS + bias_n) begin
            s.region = REG_BIAS;
            s.idx    = IDX_W'(ai - BASE_BIAS);
        end else if (ai >= BASE_MOD && ai < BASE_MOD + mod_n) begin
            s.region = REG_MOD;
            s.idx    = IDX_W'(ai - BASE_MOD);
        end
        return s;
    endfunction

    // Byte idx of an nbytes-wide field, most-significant byte first.
    function automatic logic [BYTE_W-1:0] msb_first_byte(input logic [WORD_W-1:0] v,
                                                         input int nbytes,
                                                         input logic [IDX_W-1:0] idx);
        return v[(nbytes - 1 - int'(idx)) * BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/pwlock_store.sv
module pwlock_store
    import pwlock_pkg::*;
#(
    parameter int CFG_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pfail_i,
    input  logic                      wr_en_i,
    input  slot_t                     slot_i,
    input  logic [BYTE_W-1:0]         wdata_i,
    output logic [KEY_W-1:0]          entry_o,
    output logic [KEY_W-1:0]          key_o,
    output logic [CFG_BYTES*BYTE_W-1:0] cfg_o,
    output logic                      unlocked_o
);

    logic [KEY_W-1:0]            entry_q;
    logic [KEY_W-1:0]            key_q;
    logic [CFG_BYTES*BYTE_W-1:0] cfg_q;
    int                          key_sh;
    int                          cfg_sh;

    always_comb begin
        key_sh = (KEY_BYTES - 1 - int'(slot_i.idx)) * BYTE_W;
        cfg_sh = int'(slot_i.idx) * BYTE_W;
    end

    // Unlock is derived from present contents every cycle.
    assign unlocked_o = (entry_q == key_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '1;
            key_q   <= '0;
            cfg_q   <= '0;
        end else begin
            if (pfail_i) begin
                entry_q <= '1;
            end else if (wr_en_i && slot_i.region == REG_ENTRY) begin
                entry_q[key_sh +: BYTE_W] <= wdata_i;
            end
            if (wr_en_i && unlocked_o && slot_i.region == REG_KEY) begin
                key_q[key_sh +: BYTE_W] <= wdata_i;
            end
            if (wr_en_i && unlocked_o && slot_i.region == REG_CFG) begin
                cfg_q[cfg_sh +: BYTE_W] <= wdata_i;
            end
        end
    end

    assign entry_o = entry_q;
    assign key_o   = key_q;
    assign cfg_o   = cfg_q;

endmodule

// File: rtl/pwlock_rdmux.sv
module pwlock_rdmux
    import pwlock_pkg::*;
#(
    parameter int CFG_BYTES = 8,
    parameter int BIAS_W    = 18,
    parameter int MOD_W     = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en_i,
    input  slot_t                       slot_i,
    input  logic                        halt_i,
    input  logic                        unlocked_i,
    input  logic [KEY_W-1:0]            entry_i,
    input  logic [KEY_W-1:0]            key_i,
    input  logic [CFG_BYTES*BYTE_W-1:0] cfg_i,
    input  logic [BIAS_W-1:0]           bias_i,
    input  logic [MOD_W-1:0]            mod_i,
    output logic [BYTE_W-1:0]           rdata_o
);

    localparam int BIAS_BYTES = (BIAS_W + BYTE_W - 1) / BYTE_W;
    localparam int MOD_BYTES  = (MOD_W + BYTE_W - 1) / BYTE_W;

    logic [WORD_W-1:0] bias_wide;
    logic [WORD_W-1:0] mod_wide;
    logic              dac_open;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] rdata_q;

    assign bias_wide = WORD_W'(bias_i);
    assign mod_wide  = WORD_W'(mod_i);
    assign dac_open  = halt_i && unlocked_i;

    always_comb begin
        rd_byte = '0;
        unique case (slot_i.region)
            REG_ENTRY: rd_byte = msb_first_byte(entry_i, KEY_BYTES, slot_i.idx);
            REG_KEY:   rd_byte = unlocked_i ? msb_first_byte(key_i, KEY_BYTES, slot_i.idx) : '0;
            REG_CFG:   rd_byte = cfg_i[int'(slot_i.idx) * BYTE_W +: BYTE_W];
            REG_BIAS:  rd_byte = dac_open ? msb_first_byte(bias_wide, BIAS_BYTES, slot_i.idx) : '0;
            REG_MOD:   rd_byte = dac_open ? msb_first_byte(mod_wide, MOD_BYTES, slot_i.idx) : '0;
            default:   rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= rd_byte;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/pwlock_ctrl.sv
module pwlock_ctrl
    import pwlock_pkg::*;
#(
    parameter int CFG_BYTES = 8,
    parameter int BIAS_W    = 18,
    parameter int MOD_W     = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pfail_i,
    input  logic                        halt_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BYTE_W-1:0]           wdata_i,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    output logic [BYTE_W-1:0]           rdata_o,
    input  logic [BIAS_W-1:0]           bias_code_i,
    input  logic [MOD_W-1:0]            mod_code_i,
    output logic [CFG_BYTES*BYTE_W-1:0] cfg_o
);

    localparam int BIAS_BYTES = (BIAS_W + BYTE_W - 1) / BYTE_W;
    localparam int MOD_BYTES  = (MOD_W + BYTE_W - 1) / BYTE_W;

    slot_t            slot;
    logic [KEY_W-1:0] entry_q;
    logic [KEY_W-1:0] key_q;
    logic             unlocked;

    always_comb begin
        slot = decode_slot(addr_i, CFG_BYTES, BIAS_BYTES, MOD_BYTES);
    end

    pwlock_store #(
        .CFG_BYTES (CFG_BYTES)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .pfail_i    (pfail_i),
        .wr_en_i    (wr_en_i),
        .slot_i     (slot),
        .wdata_i    (wdata_i),
        .entry_o    (entry_q),
        .key_o      (key_q),
        .cfg_o      (cfg_o),
        .unlocked_o (unlocked)
    );

    pwlock_rdmux #(
        .CFG_BYTES (CFG_BYTES),
        .BIAS_W    (BIAS_W),
        .MOD_W     (MOD_W)
    ) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .rd_en_i    (rd_en_i),
        .slot_i     (slot),
        .halt_i     (halt_i),
        .unlocked_i (unlocked),
        .entry_i    (entry_q),
        .key_i      (key_q),
        .cfg_i      (cfg_o),
        .bias_i     (bias_code_i),
        .mod_i      (mod_code_i),
        .rdata_o    (rdata_o)
    );

endmodule

// File: rtl/pwlock_chk.sv
module pwlock_chk
    import pwlock_pkg::*;
#(
    parameter int CFG_BYTES = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        pfail_i,
    input logic                        halt_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [BYTE_W-1:0]           wdata_i,
    input logic                        wr_en_i,
    input logic                        rd_en_i,
    input logic [BYTE_W-1:0]           rdata_o,
    input logic [CFG_BYTES*BYTE_W-1:0] cfg_o,
    input logic [KEY_W-1:0]            entry_q,
    input logic [KEY_W-1:0]            key_q,
    input logic                        unlocked
);

    logic key_addr;
    logic dac_addr;
    assign key_addr = (addr_i >= ADDR_W'(BASE_KEY)) && (addr_i < ADDR_W'(BASE_KEY + KEY_BYTES));
    assign dac_addr = (addr_i >= ADDR_W'(BASE_BIAS)) && (addr_i < ADDR_W'(BASE_MOD + 2));

    a_r3_locked_key_frozen: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(key_q));

    a_r3_locked_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(cfg_o));

    a_r2_entry_write_taken: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADDR_W'(BASE_ENTRY) && !pfail_i) |=> (entry_q[KEY_W-1 -: BYTE_W] == $past(wdata_i)));

    a_r7_pfail_entry_ones: assert property (@(posedge clk) disable iff (rst)
        pfail_i |=> (entry_q == '1));

    a_r5_key_read_masked: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && key_addr && !unlocked) |=> (rdata_o == '0));

    a_r8_dac_read_masked: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && dac_addr && !(halt_i && unlocked)) |=> (rdata_o == '0));

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rdata_o));

endmodule

bind pwlock_ctrl pwlock_chk #(
    .CFG_BYTES (CFG_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pfail_i  (pfail_i),
    .halt_i   (halt_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .rdata_o  (rdata_o),
    .cfg_o    (cfg_o),
    .entry_q  (entry_q),
    .key_q    (key_q),
    .unlocked (unlocked)
);

// File: tb/tb_pwlock_ctrl.sv
module tb_pwlock_ctrl;

    localparam int CFG_N  = 8;
    localparam int BIAS_W = 18;
    localparam int MOD_W  = 12;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 pfail = 1'b0;
    logic                 halt = 1'b0;
    logic [7:0]           addr = '0;
    logic [7:0]           wdata = '0;
    logic                 wr = 1'b0;
    logic                 rd = 1'b0;
    logic [7:0]           rdata;
    logic [BIAS_W-1:0]    bias = '0;
    logic [MOD_W-1:0]     modc = '0;
    logic [CFG_N*8-1:0]   cfg;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_entry;
    logic [31:0] m_key;
    logic [7:0]  m_cfg [CFG_N];

    always #10 clk = ~clk;

    pwlock_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .pfail_i     (pfail),
        .halt_i      (halt),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .wr_en_i     (wr),
        .rd_en_i     (rd),
        .rdata_o     (rdata),
        .bias_code_i (bias),
        .mod_code_i  (modc),
        .cfg_o       (cfg)
    );

    function automatic logic [7:0] exp_rd(input int a);
        logic open;
        open = (m_entry == m_key);
        if (a < 4)                 return 8'((m_entry >> (8 * (3 - a))) & 32'hFF);
        if (a < 8)                 return open ? 8'((m_key >> (8 * (7 - a))) & 32'hFF) : 8'h00;
        if (a < 8 + CFG_N)         return m_cfg[a - 8];
        if (a >= 16 && a < 19)     return (halt && open) ? 8'((32'(bias) >> (8 * (18 - a))) & 32'hFF) : 8'h00;
        if (a >= 20 && a < 22)     return (halt && open) ? 8'((32'(modc) >> (8 * (21 - a))) & 32'hFF) : 8'h00;
        return 8'h00;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 4)  return "R6";
        if (a < 8)  return "R5";
        if (a < 16) return "R4";
        if (a < 22) return "R8";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input int a);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h", req, a, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        logic open;
        open = (m_entry == m_key);
        @(negedge clk);
        addr = 8'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        if (a < 4) m_entry[8 * (3 - a) +: 8] = d;
        else if (open && a < 8) m_key[8 * (7 - a) +: 8] = d;
        else if (open && a >= 8 && a < 8 + CFG_N) m_cfg[a - 8] = d;
    endtask

    task automatic do_read(input int a, input string req);
        @(negedge clk);
        addr = 8'(a); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check(req, rdata, exp_rd(a), a);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) begin
            do_read(a, (req == "") ? tag_of(a) : req);
        end
    endtask

    task automatic pulse_pfail(input bit with_write);
        @(negedge clk);
        pfail = 1'b1;
        if (with_write) begin addr = 8'h00; wdata = 8'h12; wr = 1'b1; end
        @(negedge clk);
        pfail = 1'b0; wr = 1'b0;
        m_entry = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        m_entry = 32'hFFFF_FFFF;
        m_key   = '0;
        for (int i = 0; i < CFG_N; i++) m_cfg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state over the whole window
        bias = 18'h2_A5C3; modc = 12'hB7E;
        sweep("R1");

        // R3: locked writes to key and configuration are dropped
        for (int a = 4; a < 16; a++) do_write(a, 8'(8'h30 + a));
        sweep("R3");

        // R2: entry writes accepted, unlock on match with key 0
        do_write(0, 8'h00); do_read(0, "R2");
        do_write(1, 8'h00); do_write(2, 8'h00);
        do_read(4, "R2");
        do_write(3, 8'h00);
        do_read(7, "R2");

        // R4: unlocked writes to configuration take effect
        for (int a = 8; a < 16; a++) do_write(a, 8'(8'hC0 ^ (a * 7)));
        sweep("");
        for (int i = 0; i < CFG_N; i++) begin
            checks++;
            if (cfg[i*8 +: 8] !== m_cfg[i]) begin
                fails++;
                $display("FAIL R4 cfg_o byte %0d actual=0x%02h expected=0x%02h", i, cfg[i*8 +: 8], m_cfg[i]);
            end
        end

        // R8/R9: DAC visibility under halt x lock, all-ones padding check
        bias = '1; modc = '1;
        halt = 1'b0; for (int a = 16; a < 24; a++) do_read(a, "R8");
        halt = 1'b1; for (int a = 16; a < 24; a++) do_read(a, "R9");
        bias = 18'h1_0203; modc = 12'h405;
        for (int a = 16; a < 24; a++) do_read(a, "R8");
        // R11: writes to DAC addresses do nothing
        for (int a = 16; a < 22; a++) do_write(a, 8'h99);
        for (int a = 16; a < 22; a++) do_read(a, "R11");

        // R10: changing the key while unlocked relocks at once
        do_write(7, 8'h5A);
        do_read(7, "R10");
        do_write(8, 8'h77);
        do_read(8, "R10");
        halt = 1'b1; do_read(16, "R10");
        do_write(3, 8'h5A);
        do_read(7, "R10");
        do_write(4, 8'hA5);
        do_write(5, 8'hC3);
        do_read(5, "R10");
        do_read(4, "R10");
        do_write(0, 8'hA5);
        sweep("");

        // R7: power fail resets entry, keeps key and configuration
        pulse_pfail(1'b0);
        sweep("R7");
        do_write(0, 8'hA5); do_write(3, 8'h5A);
        do_read(4, "R7"); do_read(7, "R7"); do_read(9, "R7");
        pulse_pfail(1'b1);
        do_read(0, "R7"); do_read(4, "R7");

        // R11: read data holds until the next strobe
        do_read(2, "R11");
        held = exp_rd(2);
        do_write(2, 8'h3C);
        repeat (3) @(negedge clk);
        check("R11", rdata, held, 2);
        do_read(2, "R11");

        // R1: synchronous reset mid-run returns to defaults
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", rdata, 8'h00, 0);
        m_entry = 32'hFFFF_FFFF; m_key = '0;
        for (int i = 0; i < CFG_N; i++) m_cfg[i] = 8'h00;
        sweep("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule